// File: doc/BRIEF.md
# Periodic Time-Base Interrupt Generator

This block sits beside a real-time clock counter. It sees a one-cycle tick once per second, together with the current seconds, minutes and hours counts, and turns the chosen tick rate into interrupt events. A 2-bit period selector picks one rate: every second, every minute, every hour or every day. The minute, hour and day rates fire only on ticks where the lower time fields read zero. Each rate has its own sticky status bit. A separate alarm event sets another status bit, and that bit drives a level-type alarm output.

All four rates share one periodic interrupt output. That output is a single-cycle pulse, so it suits an edge-sensitive input on an interrupt controller. A global enable bit gates the pulse, but the status bits keep updating while the enable is 0. Software clears a status bit by writing 1 to its position. The alarm output follows the alarm status bit, so it stays high until software clears that bit.

Top module: `rtc_tick_irq`

## Requirements
- R1: After reset, status reads 0x00, the period selector is 0, the pulse enable is 0, and both interrupt outputs are low.
- R2: With selector 0, every tick sets status bit 2.
- R3: With selector 1, a tick sets status bit 3 only if seconds equal zero.
- R4: With selector 2, a tick sets status bit 4 only if seconds and minutes both equal zero.
- R5: With selector 3, a tick sets status bit 5 only if seconds, minutes and hours all equal zero.
- R6: A tick that sets a periodic status bit while the enable is 1 raises `period_irq_o` for exactly the one cycle after the tick edge.
- R7: While the enable is 0, qualifying ticks still set their status bit but raise no pulse.
- R8: A tick that does not qualify for the selected rate changes no status bit and raises no pulse, and status bits 0, 1 and 7 always read 0.
- R9: A clear write removes only the status bits written as 1. A bit that is set and cleared at the same edge ends set. Status bits stay set until they are cleared.
- R10: An alarm event sets status bit 6. `alarm_irq_o` is high exactly while bit 6 is set, and it falls at the edge that clears bit 6.
- R11: A configuration write loads the selector and the enable at its edge. A tick at that same edge is judged with the old configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle once-per-second tick |
| sec_i | input | SEC_W | Current seconds count |
| min_i | input | MIN_W | Current minutes count |
| hr_i | input | HR_W | Current hours count |
| cfg_we_i | input | 1 | Load period selector and enable |
| cfg_period_i | input | 2 | Period selector: 0 second, 1 minute, 2 hour, 3 day |
| cfg_en_i | input | 1 | Periodic pulse enable |
| alarm_evt_i | input | 1 | Alarm event, sets status bit 6 |
| clr_we_i | input | 1 | Status clear strobe |
| clr_mask_i | input | 8 | Write-1-to-clear mask for status |
| status_o | output | 8 | Status: bits 2..5 periodic, bit 6 alarm |
| period_irq_o | output | 1 | Periodic interrupt pulse |
| alarm_irq_o | output | 1 | Level alarm interrupt |

## Verification
Each result is due one register stage after its stimulus. A tick, a clear or an alarm event at a rising edge shows up on status and on both outputs right after that edge. The bench drives inputs on falling edges and samples at the next falling edge, half a cycle after the edge that captured them. It checks the pulse again one cycle later, where it must be low. It sweeps every selector, both enable values, and zero and non-zero values of each time field, and it compares the whole status word against an arithmetic model.

// File: rtl/rtc_tick_pkg.sv
package rtc_tick_pkg;

    typedef enum logic [1:0] {
        PER_SEC  = 2'd0,
        PER_MIN  = 2'd1,
        PER_HOUR = 2'd2,
        PER_DAY  = 2'd3
    } period_e;

    localparam int NUM_PER   = 4;
    localparam int STAT_W    = 8;
    localparam int PER_BASE  = 2;
    localparam int ALARM_BIT = 6;

    typedef struct packed {
        period_e sel;
        logic    en;
    } tick_cfg_t;

    // mask of the status bits that hardware can ever set
    function automatic logic [STAT_W-1:0] live_bits();
        logic [STAT_W-1:0] m;
        m = '0;
        for (int k = 0; k < NUM_PER; k++) m[PER_BASE+k] = 1'b1;
        m[ALARM_BIT] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/rtc_period_match.sv
module rtc_period_match
    import rtc_tick_pkg::*;
#(
    parameter int SEC_W = 6,
    parameter int MIN_W = 6,
    parameter int HR_W  = 5
) (
    input  logic             tick,
    input  logic [SEC_W-1:0] sec,
    input  logic [MIN_W-1:0] min,
    input  logic [HR_W-1:0]  hr,
    input  period_e          sel,
    output logic [NUM_PER-1:0] hit
);
    logic [NUM_PER-1:0] zero_run;

    always_comb begin
        zero_run[0] = 1'b1;
        zero_run[1] = (sec == '0);
        zero_run[2] = zero_run[1] && (min == '0);
        zero_run[3] = zero_run[2] && (hr == '0);
    end

    for (genvar k = 0; k < NUM_PER; k++) begin : g_hit
        assign hit[k] = tick && (sel == period_e'(k)) && zero_run[k];
    end
endmodule

// File: rtl/rtc_status_bits.sv
module rtc_status_bits
    import rtc_tick_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_PER-1:0] per_set,
    input  logic               alarm_set,
    input  logic               clr_we,
    input  logic [STAT_W-1:0]  clr_mask,
    output logic [STAT_W-1:0]  status
);
    localparam logic [STAT_W-1:0] LIVE = live_bits();

    logic [STAT_W-1:0] set_vec;
    logic [STAT_W-1:0] clr_vec;

    always_comb begin
        set_vec = '0;
        for (int k = 0; k < NUM_PER; k++) set_vec[PER_BASE+k] = per_set[k];
        set_vec[ALARM_BIT] = alarm_set;
        clr_vec = clr_we ? clr_mask : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) status <= '0;
        else     status <= ((status & ~clr_vec) | set_vec) & LIVE;
    end
endmodule

// File: rtl/rtc_pulse_gen.sv
module rtc_pulse_gen (
    input  logic clk,
    input  logic rst,
    input  logic fire,
    input  logic en,
    output logic pulse
);
    always_ff @(posedge clk) begin
        if (rst) pulse <= 1'b0;
        else     pulse <= fire && en;
    end
endmodule

// File: rtl/rtc_tick_irq.sv
module rtc_tick_irq
    import rtc_tick_pkg::*;
#(
    parameter int SEC_W = 6,
    parameter int MIN_W = 6,
    parameter int HR_W  = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  logic [SEC_W-1:0] sec_i,
    input  logic [MIN_W-1:0] min_i,
    input  logic [HR_W-1:0]  hr_i,
    input  logic             cfg_we_i,
    input  logic [1:0]       cfg_period_i,
    input  logic             cfg_en_i,
    input  logic             alarm_evt_i,
    input  logic             clr_we_i,
    input  logic [7:0]       clr_mask_i,
    output logic [7:0]       status_o,
    output logic             period_irq_o,
    output logic             alarm_irq_o
);
    tick_cfg_t          cfg_q;
    logic [NUM_PER-1:0] hit;
    logic [STAT_W-1:0]  status;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q.sel <= PER_SEC;
            cfg_q.en  <= 1'b0;
        end else if (cfg_we_i) begin
            cfg_q.sel <= period_e'(cfg_period_i);
            cfg_q.en  <= cfg_en_i;
        end
    end

    rtc_period_match #(.SEC_W(SEC_W), .MIN_W(MIN_W), .HR_W(HR_W)) u_match (
        .tick (tick_i),
        .sec  (sec_i),
        .min  (min_i),
        .hr   (hr_i),
        .sel  (cfg_q.sel),
        .hit  (hit)
    );

    rtc_status_bits u_stat (
        .clk       (clk),
        .rst       (rst),
        .per_set   (hit),
        .alarm_set (alarm_evt_i),
        .clr_we    (clr_we_i),
        .clr_mask  (clr_mask_i),
        .status    (status)
    );

    rtc_pulse_gen u_pulse (
        .clk   (clk),
        .rst   (rst),
        .fire  (|hit),
        .en    (cfg_q.en),
        .pulse (period_irq_o)
    );

    assign status_o    = status;
    assign alarm_irq_o = status[ALARM_BIT];
endmodule

// File: rtl/rtc_tick_irq_chk.sv
module rtc_tick_irq_chk (
    input logic       clk,
    input logic       rst,
    input logic       tick_i,
    input logic       alarm_evt_i,
    input logic       clr_we_i,
    input logic [7:0] clr_mask_i,
    input logic [7:0] status_o,
    input logic       period_irq_o,
    input logic       alarm_irq_o
);
    AST_PULSE_NEEDS_TICK: assert property (@(posedge clk) disable iff (rst)
        period_irq_o |-> $past(tick_i)); // R6

    AST_PULSE_HAS_STATUS: assert property (@(posedge clk) disable iff (rst)
        period_irq_o |-> (status_o[5:2] != 4'b0)); // R7

    AST_SEC_SET_NEEDS_TICK: assert property (@(posedge clk) disable iff (rst)
        $rose(status_o[2]) |-> $past(tick_i)); // R2

    AST_DAY_SET_NEEDS_TICK: assert property (@(posedge clk) disable iff (rst)
        $rose(status_o[5]) |-> $past(tick_i)); // R5

    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (status_o[7] == 1'b0) && (status_o[1:0] == 2'b0)); // R8

    AST_STICKY_SEC: assert property (@(posedge clk) disable iff (rst)
        (status_o[2] && !(clr_we_i && clr_mask_i[2])) |=> status_o[2]); // R9

    AST_ALARM_RISE: assert property (@(posedge clk) disable iff (rst)
        $rose(alarm_irq_o) |-> $past(alarm_evt_i)); // R10

    AST_ALARM_FALL: assert property (@(posedge clk) disable iff (rst)
        $fell(alarm_irq_o) |-> $past(clr_we_i && clr_mask_i[6])); // R10
endmodule

bind rtc_tick_irq rtc_tick_irq_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .tick_i       (tick_i),
    .alarm_evt_i  (alarm_evt_i),
    .clr_we_i     (clr_we_i),
    .clr_mask_i   (clr_mask_i),
    .status_o     (status_o),
    .period_irq_o (period_irq_o),
    .alarm_irq_o  (alarm_irq_o)
);

// File: tb/sim_rtc_tick_irq.sv
module sim_rtc_tick_irq;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_i = 1'b0;
    logic [5:0] sec_i = '0;
    logic [5:0] min_i = '0;
    logic [4:0] hr_i = '0;
    logic       cfg_we_i = 1'b0;
    logic [1:0] cfg_period_i = '0;
    logic       cfg_en_i = 1'b0;
    logic       alarm_evt_i = 1'b0;
    logic       clr_we_i = 1'b0;
    logic [7:0] clr_mask_i = '0;
    logic [7:0] status_o;
    logic       period_irq_o;
    logic       alarm_irq_o;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    rtc_tick_irq u0 (
        .clk(clk), .rst(rst), .tick_i(tick_i), .sec_i(sec_i), .min_i(min_i),
        .hr_i(hr_i), .cfg_we_i(cfg_we_i), .cfg_period_i(cfg_period_i),
        .cfg_en_i(cfg_en_i), .alarm_evt_i(alarm_evt_i), .clr_we_i(clr_we_i),
        .clr_mask_i(clr_mask_i), .status_o(status_o),
        .period_irq_o(period_irq_o), .alarm_irq_o(alarm_irq_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // drive for one edge, then sample half a cycle after it
    task automatic step();
        @(negedge clk);
        tick_i = 1'b0; cfg_we_i = 1'b0; alarm_evt_i = 1'b0; clr_we_i = 1'b0;
    endtask

    task automatic do_cfg(input logic [1:0] p, input logic en);
        cfg_we_i = 1'b1; cfg_period_i = p; cfg_en_i = en;
        step();
    endtask

    task automatic do_tick(input logic [5:0] s, input logic [5:0] m, input logic [4:0] h);
        tick_i = 1'b1; sec_i = s; min_i = m; hr_i = h;
        step();
    endtask

    task automatic do_clr(input logic [7:0] mask);
        clr_we_i = 1'b1; clr_mask_i = mask;
        step();
    endtask

    function automatic logic qualifies(input int p, input int s, input int m, input int h);
        case (p)
            0: return 1'b1;
            1: return s == 0;
            2: return (s == 0) && (m == 0);
            default: return (s == 0) && (m == 0) && (h == 0);
        endcase
    endfunction

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R1 status", status_o, 8'h00);
        chk("R1 pulse", period_irq_o, 0);
        chk("R1 alarm", alarm_irq_o, 0);
        // reset config: selector 0, enable 0
        do_tick(6'd5, 6'd5, 5'd5);
        chk("R1 R2 reset selector", status_o, 8'h04);
        chk("R1 R7 reset enable", period_irq_o, 0);
        do_clr(8'hFF);
        chk("R9 clear all", status_o, 8'h00);

        // sweep of selectors, enable, zero/non-zero time fields
        for (int p = 0; p < 4; p++) begin
            for (int en = 0; en < 2; en++) begin
                do_cfg(p[1:0], en[0]);
                for (int c = 0; c < 8; c++) begin
                    int s, m, h;
                    logic q;
                    s = c[0] ? 17 : 0;
                    m = c[1] ? 42 : 0;
                    h = c[2] ? 9 : 0;
                    q = qualifies(p, s, m, h);
                    do_tick(s[5:0], m[5:0], h[4:0]);
                    // R2 R3 R4 R5 R8
                    chk($sformatf("R2 R3 R4 R5 R8 status p=%0d c=%0d", p, c),
                        status_o, q ? (32'h4 << p) : 32'h0);
                    chk($sformatf("R6 R7 pulse p=%0d en=%0d c=%0d", p, en, c),
                        period_irq_o, q && (en == 1));
                    do_clr(8'hFF);
                    chk("R6 single cycle", period_irq_o, 0);
                    chk("R9 cleared", status_o, 8'h00);
                end
            end
        end

        // sticky, selective clear, set wins
        do_cfg(2'd0, 1'b1);
        do_tick(6'd3, 6'd3, 5'd3);
        chk("R2 set", status_o, 8'h04);
        step();
        chk("R9 sticky", status_o, 8'h04);
        tick_i = 1'b1; clr_we_i = 1'b1; clr_mask_i = 8'h04;
        step();
        chk("R9 set wins", status_o, 8'h04);
        do_clr(8'h08);
        chk("R9 only written bits", status_o, 8'h04);
        do_cfg(2'd1, 1'b1);
        do_tick(6'd0, 6'd30, 5'd1);
        chk("R3 accumulate", status_o, 8'h0C);
        do_clr(8'h04);
        chk("R9 partial clear", status_o, 8'h08);

        // configuration timing: tick at cfg edge uses old selector (1)
        cfg_we_i = 1'b1; cfg_period_i = 2'd0; cfg_en_i = 1'b1;
        tick_i = 1'b1; sec_i = 6'd7;
        step();
        chk("R11 old config", status_o, 8'h08);
        chk("R11 old config pulse", period_irq_o, 0);
        do_tick(6'd7, 6'd7, 5'd7);
        chk("R11 new config", status_o, 8'h0C);
        do_clr(8'hFF);

        // alarm level
        alarm_evt_i = 1'b1;
        step();
        chk("R10 alarm set", status_o, 8'h40);
        chk("R10 alarm high", alarm_irq_o, 1);
        chk("R10 no periodic pulse", period_irq_o, 0);
        repeat (3) step();
        chk("R10 alarm holds", alarm_irq_o, 1);
        do_clr(8'h3C);
        chk("R10 other clear keeps alarm", alarm_irq_o, 1);
        do_clr(8'h40);
        chk("R10 alarm falls", alarm_irq_o, 0);
        chk("R10 status after clear", status_o, 8'h00);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule